// File: doc/BRIEF.md
# Banked Page Select Register with Slot Save and Restore

This block holds the current page number that steers address decoding into one bank of a memory-mapped register space. Software changes the page with one byte written over a simple synchronous register bus. Besides the page value, that byte carries a two-bit action code and a slot number. The slot number picks one of four hidden three-bit storage slots.

Three actions exist. A direct write only replaces the page. A save-and-switch write replaces the page and, in the same clock, parks the old page in the chosen slot. A restore write ignores the page bits it carries and reloads the page from the chosen slot. One write therefore switches banks and keeps the way back, with nothing else able to step in between.

The register reads back the slot number last written and the current page. The action code and the spare bit always read as zero. The page also drives a dedicated output toward the decoders.

Top module: `bank_sel_reg`

## Requirements
- R1: After reset the page, the stored slot number and all four storage slots are zero, so `rd_data` reads 8'h00, `page_o` is 0 and a restore from any slot yields page 0.
- R2: A write whose action code (`wr_data[7:6]`) is 2'b00 or 2'b01 loads `wr_data[2:0]` into the page one clock later and leaves every storage slot unchanged.
- R3: A write with action code 2'b10 loads `wr_data[2:0]` into the page and, in the same clock, copies the page held before that write into the slot numbered by `wr_data[5:4]`.
- R4: A write with action code 2'b11 loads the page from the slot numbered by `wr_data[5:4]`, and the page bits `wr_data[2:0]` of that write have no effect.
- R5: `rd_data` is {2'b00, stored slot number, 1'b0, page}: bits [7:6] and bit 3 always read zero, bits [5:4] hold the slot number of the most recent write of any action, and bits [2:0] equal `page_o`.
- R6: In a cycle with `wr_en` low, the page, the stored slot number and the storage slots keep their values.
- R7: A save-and-switch write followed in the very next clock by a restore write to the same slot returns the page that the save stored.
- R8: A 1 written to the spare bit `wr_data[3]` changes nothing that any action would otherwise do.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Write strobe; one write per clock where high |
| wr_data | input | 8 | Write byte: action [7:6], slot [5:4], spare [3], page [2:0] |
| rd_data | output | 8 | Read byte: zeros, slot number, zero, page |
| page_o | output | 3 | Current page toward the address decoders |

## Verification
Every write is captured at the rising edge at which `wr_en` is sampled high. Its effect on `page_o` and `rd_data` is therefore due one clock later, because both outputs come straight from registers. The bench drives its inputs 2 ns after a rising edge. Each expected item is tagged with the cycle in which the result is due, and the monitor compares it at the falling edge of that cycle. Idle cycles push expected items as well, so the results of holding are checked on the same one-clock schedule as the writes.

// File: rtl/bank_sel_pkg.sv
package bank_sel_pkg;

  // Action codes carried in the two top bits of a write
  typedef enum logic [1:0] {
    ACT_DIRECT_A = 2'b00,
    ACT_DIRECT_B = 2'b01,
    ACT_SAVE     = 2'b10,
    ACT_LOAD     = 2'b11
  } bank_act_e;

  function automatic bank_act_e act_of(input logic [1:0] code);
    return bank_act_e'(code);
  endfunction

endpackage

// File: rtl/bank_sel_decode.sv
module bank_sel_decode
  import bank_sel_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int IDX_W  = 2,
  parameter int PAGE_W = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wr_data,
  output logic              dir_en,
  output logic              save_en,
  output logic              load_en,
  output logic [IDX_W-1:0]  cmd_idx,
  output logic [PAGE_W-1:0] cmd_page
);
  localparam int ACT_LSB = DATA_W - 2;
  localparam int IDX_LSB = ACT_LSB - IDX_W;

  bank_act_e act;

  always_comb begin
    act      = act_of(wr_data[DATA_W-1:ACT_LSB]);
    cmd_idx  = wr_data[IDX_LSB +: IDX_W];
    cmd_page = wr_data[PAGE_W-1:0];
    dir_en   = 1'b0;
    save_en  = 1'b0;
    load_en  = 1'b0;
    if (wr_en) begin
      unique case (act)
        ACT_DIRECT_A, ACT_DIRECT_B: dir_en  = 1'b1;
        ACT_SAVE:                   save_en = 1'b1;
        ACT_LOAD:                   load_en = 1'b1;
        default:                    dir_en  = 1'b0;
      endcase
    end
  end

  // R2 R3 R4: a write selects exactly one action, none without a write
  assert_one_action_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $countones({dir_en, save_en, load_en}) == (wr_en ? 1 : 0));

endmodule

// File: rtl/bank_sel_slots.sv
module bank_sel_slots #(
  parameter int IDX_W  = 2,
  parameter int PAGE_W = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              save_en,
  input  logic [IDX_W-1:0]  sel_idx,
  input  logic [PAGE_W-1:0] save_val,
  output logic [PAGE_W-1:0] slot_val
);
  localparam int NUM_SLOTS = 1 << IDX_W;

  logic [PAGE_W-1:0] slot_q [NUM_SLOTS];

  for (genvar g = 0; g < NUM_SLOTS; g++) begin : g_slot
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        slot_q[g] <= '0;
      end else if (save_en && (sel_idx == IDX_W'(g))) begin
        slot_q[g] <= save_val;
      end
    end

    // R2 R6: a slot changes only through a save aimed at it
    assert_slot_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
      !(save_en && (sel_idx == IDX_W'(g))) |=> $stable(slot_q[g]));
  end

  assign slot_val = slot_q[sel_idx];

  // R3: the saved page lands in the addressed slot
  assert_save_store_R3: assert property (@(posedge clk) disable iff (!rst_n)
    save_en |=> slot_q[$past(sel_idx)] == $past(save_val));

endmodule

// File: rtl/bank_sel_page.sv
module bank_sel_page #(
  parameter int IDX_W  = 2,
  parameter int PAGE_W = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic              dir_en,
  input  logic              save_en,
  input  logic              load_en,
  input  logic [IDX_W-1:0]  cmd_idx,
  input  logic [PAGE_W-1:0] cmd_page,
  input  logic [PAGE_W-1:0] slot_val,
  output logic [PAGE_W-1:0] page_q,
  output logic [IDX_W-1:0]  idx_q
);
  logic [PAGE_W-1:0] page_d;

  always_comb begin
    page_d = page_q;
    if (dir_en || save_en) begin
      page_d = cmd_page;
    end else if (load_en) begin
      page_d = slot_val;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      page_q <= '0;
      idx_q  <= '0;
    end else begin
      page_q <= page_d;
      if (wr_en) begin
        idx_q <= cmd_idx;
      end
    end
  end

  // R2 R3: direct and save writes take the written page
  assert_page_take_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (dir_en || save_en) |=> page_q == $past(cmd_page));

  // R4: a restore takes the slot contents
  assert_page_load_R4: assert property (@(posedge clk) disable iff (!rst_n)
    load_en |=> page_q == $past(slot_val));

  // R6: idle cycles hold page and slot number
  assert_idle_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> ($stable(page_q) && $stable(idx_q)));

endmodule

// File: rtl/bank_sel_reg.sv
module bank_sel_reg #(
  parameter int DATA_W = 8,
  parameter int IDX_W  = 2,
  parameter int PAGE_W = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wr_data,
  output logic [DATA_W-1:0] rd_data,
  output logic [PAGE_W-1:0] page_o
);
  localparam int ACT_LSB = DATA_W - 2;
  localparam int IDX_LSB = ACT_LSB - IDX_W;

  logic              dir_en, save_en, load_en;
  logic [IDX_W-1:0]  cmd_idx, idx_q;
  logic [PAGE_W-1:0] cmd_page, slot_val, page_q;

  bank_sel_decode #(.DATA_W(DATA_W), .IDX_W(IDX_W), .PAGE_W(PAGE_W)) u_decode (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en    (wr_en),
    .wr_data  (wr_data),
    .dir_en   (dir_en),
    .save_en  (save_en),
    .load_en  (load_en),
    .cmd_idx  (cmd_idx),
    .cmd_page (cmd_page)
  );

  bank_sel_slots #(.IDX_W(IDX_W), .PAGE_W(PAGE_W)) u_slots (
    .clk      (clk),
    .rst_n    (rst_n),
    .save_en  (save_en),
    .sel_idx  (cmd_idx),
    .save_val (page_q),
    .slot_val (slot_val)
  );

  bank_sel_page #(.IDX_W(IDX_W), .PAGE_W(PAGE_W)) u_page (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en    (wr_en),
    .dir_en   (dir_en),
    .save_en  (save_en),
    .load_en  (load_en),
    .cmd_idx  (cmd_idx),
    .cmd_page (cmd_page),
    .slot_val (slot_val),
    .page_q   (page_q),
    .idx_q    (idx_q)
  );

  always_comb begin
    rd_data                      = '0;
    rd_data[IDX_LSB +: IDX_W]    = idx_q;
    rd_data[PAGE_W-1:0]          = page_q;
  end

  assign page_o = page_q;

  // R5: the read byte mirrors the page output and hides the action code
  assert_read_view_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_data[PAGE_W-1:0] == page_o) && (rd_data[DATA_W-1:ACT_LSB] == 2'b00));

  // R7: save then restore of the same slot returns the saved page
  assert_save_then_load_R7: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(save_en) && load_en && (cmd_idx == $past(cmd_idx)))
      |=> page_o == $past(page_o, 2));

endmodule

// File: tb/test_bank_sel_reg.sv
module test_bank_sel_reg;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wr_en = 1'b0;
  logic [7:0] wr_data = 8'h00;
  logic [7:0] rd_data;
  logic [2:0] page_o;

  int n_cmp = 0;
  int n_bad = 0;
  int cyc = 0;
  bit done = 1'b0;

  typedef struct {
    logic [7:0] rd;
    logic [2:0] pg;
    int         due;
    string      req;
  } exp_t;

  exp_t exp_q[$];

  // reference model state
  logic [2:0] m_page;
  logic [1:0] m_idx;
  logic [2:0] m_slot [4];

  bank_sel_reg i_bank_sel_reg (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (wr_en),
    .wr_data (wr_data),
    .rd_data (rd_data),
    .page_o  (page_o)
  );

  always #4 clk = ~clk;

  always @(posedge clk) cyc <= cyc + 1;

  function automatic logic [7:0] view();
    return {2'b00, m_idx, 1'b0, m_page};
  endfunction

  // driver: one write (or idle) per cycle, expected item due next cycle
  task automatic drive(input logic en, input logic [7:0] d, input string req);
    @(posedge clk);
    #2;
    wr_en   = en;
    wr_data = d;
    if (en) begin
      m_idx = d[5:4];
      case (d[7:6])
        2'b10: begin m_slot[d[5:4]] = m_page; m_page = d[2:0]; end
        2'b11: m_page = m_slot[d[5:4]];
        default: m_page = d[2:0];
      endcase
    end
    exp_q.push_back('{rd: view(), pg: m_page, due: cyc + 1, req: req});
  endtask

  task automatic wr(input logic [1:0] act, input logic [1:0] idx, input logic rsv,
                    input logic [2:0] pg, input string req);
    drive(1'b1, {act, idx, rsv, pg}, req);
  endtask

  task automatic idle(input string req);
    drive(1'b0, 8'h00, req);
  endtask

  // monitor: compare due items at the falling edge
  always @(negedge clk) begin
    while (exp_q.size() > 0 && exp_q[0].due <= cyc) begin
      exp_t e;
      e = exp_q.pop_front();
      n_cmp++;
      if (rd_data !== e.rd || page_o !== e.pg) begin
        n_bad++;
        $display("FAIL %s: rd_data=%h page_o=%0d expected rd_data=%h page_o=%0d",
                 e.req, rd_data, page_o, e.rd, e.pg);
      end
    end
  end

  initial begin
    #1_000_000;
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: run did not finish, expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    m_page = '0;
    m_idx  = '0;
    for (int i = 0; i < 4; i++) m_slot[i] = '0;

    repeat (3) @(posedge clk);
    #2 rst_n = 1'b1;
    @(negedge clk);
    n_cmp++;
    if (rd_data !== 8'h00 || page_o !== 3'd0) begin
      n_bad++;
      $display("FAIL R1: rd_data=%h page_o=%0d expected rd_data=00 page_o=0", rd_data, page_o);
    end

    // R1: every slot restores zero after reset
    wr(2'b00, 2'b00, 1'b0, 3'd5, "R2 direct");
    for (int s = 0; s < 4; s++) begin
      wr(2'b11, s[1:0], 1'b0, 3'd7, "R1 reset slot restore");
      wr(2'b01, 2'b10, 1'b0, 3'd6, "R2 direct code 01");
    end

    // R2: direct writes with both codes and varied slot numbers
    wr(2'b00, 2'b11, 1'b0, 3'd1, "R2 direct");
    wr(2'b01, 2'b01, 1'b0, 3'd2, "R2 direct code 01");
    wr(2'b00, 2'b00, 1'b0, 3'd7, "R5 slot readback");

    // R6: idle holds
    idle("R6 idle hold");
    idle("R6 idle hold");

    // R3 then R7: save slot 1, restore slot 1 next clock
    wr(2'b10, 2'b01, 1'b0, 3'd3, "R3 save switch");
    wr(2'b11, 2'b01, 1'b0, 3'd0, "R7 save then restore");

    // R3: fill all slots with distinct pages
    wr(2'b00, 2'b00, 1'b0, 3'd4, "R2 direct");
    wr(2'b10, 2'b00, 1'b0, 3'd6, "R3 save slot0");
    wr(2'b10, 2'b01, 1'b0, 3'd2, "R3 save slot1");
    wr(2'b10, 2'b10, 1'b0, 3'd1, "R3 save slot2");
    wr(2'b10, 2'b11, 1'b0, 3'd5, "R3 save slot3");

    // R2: direct write must not touch slots, verified by restores
    wr(2'b00, 2'b10, 1'b0, 3'd0, "R2 direct");
    idle("R6 idle hold");

    // R4: restore out of order with garbage page bits
    wr(2'b11, 2'b10, 1'b0, 3'd7, "R4 restore slot2");
    wr(2'b11, 2'b00, 1'b0, 3'd0, "R4 restore slot0");
    wr(2'b11, 2'b11, 1'b0, 3'd3, "R4 restore slot3");
    wr(2'b11, 2'b01, 1'b0, 3'd6, "R4 restore slot1");

    // R8: spare bit set on each action
    wr(2'b00, 2'b01, 1'b1, 3'd3, "R8 spare direct");
    wr(2'b10, 2'b10, 1'b1, 3'd7, "R8 spare save");
    wr(2'b11, 2'b10, 1'b1, 3'd1, "R8 spare restore");
    wr(2'b01, 2'b00, 1'b1, 3'd2, "R8 spare direct 01");

    // R7 again on slot 3 with saved value differing from written one
    wr(2'b10, 2'b11, 1'b0, 3'd6, "R3 save slot3");
    wr(2'b11, 2'b11, 1'b0, 3'd5, "R7 save then restore");
    idle("R6 idle hold");
    idle("R5 final view");

    repeat (2) @(posedge clk);
    @(negedge clk);
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule